// File: doc/BRIEF.md
# DRAM Command Decoder with Bank Expansion

This block sits behind the command pins of a banked DRAM model. On every rising clock edge it samples three active-low strobes (chip select, write enable, refresh enable), a 20-bit location address and a 4-bit bank address. It turns them into one of five commands: idle, mode-register load, read, write or refresh. The result is a registered pulse per command, a 16-bit mask of the banks the command touches, and the location address for reads and writes.

Writes and refreshes may touch more than one bank. A write-width field in mode register 2 picks one, two or four banks per write. In the wider modes the high bank-address bits are dropped and the write covers every bank that shares the remaining low bits. A refresh-method bit picks between two forms. In one, the bank address names a single bank. In the other, the low address lines form a direct bank bitmap of at most four banks.

Each bank carries a busy countdown that is reloaded whenever a command targets it. A mode-register load is refused with an error pulse while any countdown is running. The three mode registers are exposed as outputs so their contents can be observed.

Top module: `dram_cmd_decode`

## Requirements
- R1: With cs_n high the command is idle whatever the other strobes and buses carry. nop_p pulses, no other command pulse or err is raised, bank_mask and loc_addr are zero, and no busy countdown is reloaded.
- R2: With cs_n low the strobe pair {we_n, ref_n} selects the command: 11 read, 01 write, 10 refresh, 00 mode-register load. Exactly one of nop_p, mrs_p, rd_p, wr_p, ref_p (or err alone) follows one cycle after the sampling edge.
- R3: A read sets bank_mask to the one-hot value 1<<ba and loc_addr to addr, both registered one cycle after the sampling edge.
- R4: When the write-width field mr2_q[4:3] is 00 or 11, a write targets bank ba only. loc_addr equals addr.
- R5: When the write-width field is 01, a write targets banks ba[2:0] and ba[2:0]+8.
- R6: When the write-width field is 10, a write targets the four banks ba[1:0]+4k for k = 0..3.
- R7: When refresh-method bit mr2_q[5] is 0, a refresh targets bank ba alone and addr is ignored. loc_addr is zero.
- R8: When mr2_q[5] is 1, a refresh targets the banks whose bits are set in addr[15:0], and ba is ignored. If more than four bits are set, err pulses, ref_p stays low, bank_mask is zero and no bank is marked busy.
- R9: An accepted mode-register load pulses mrs_p. It copies addr[19:2] into the register chosen by addr[1:0] (0, 1, 2). Selector 3 changes no register. Registers change by no other command.
- R10: A mode-register load sampled while any bank is busy pulses err instead of mrs_p and leaves all three registers unchanged.
- R11: Every bank in bank_mask shows in bank_busy for exactly BUSY_CYC cycles from the pulse, counting the pulse cycle. A mode-register load is accepted from the (BUSY_CYC+1)-th edge after the last targeting command.
- R12: During and right after reset all pulses, err, bank_mask, loc_addr, bank_busy and the three mode registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| ref_n | input | 1 | Refresh strobe, active low |
| addr | input | 20 | Location address, mode opcode and selector, or refresh bitmap |
| ba | input | 4 | Bank address |
| nop_p | output | 1 | Idle command pulse |
| mrs_p | output | 1 | Accepted mode-register load pulse |
| rd_p | output | 1 | Read pulse |
| wr_p | output | 1 | Write pulse |
| ref_p | output | 1 | Refresh pulse |
| bank_mask | output | 16 | Banks targeted by the pulsed command |
| loc_addr | output | 20 | Location address of a read or write, else zero |
| err | output | 1 | Refused mode-register load or over-wide refresh |
| bank_busy | output | 16 | Banks whose busy countdown is running |
| mr0_q | output | 18 | Mode register 0 |
| mr1_q | output | 18 | Mode register 1 |
| mr2_q | output | 18 | Mode register 2 (bits 4:3 write width, bit 5 refresh method) |

## Verification
The assertions assume the strobes and buses are stable at 0 or 1 across each sampling edge. They also assume a single command per cycle, with no X on cs_n once reset is released. The stimulus drives every input on the falling edge and only from known values. It sweeps the strobe combinations, every bank address in all four write-width settings, both refresh methods and all 65536 refresh bitmaps. It issues mode-register loads at every distance from a preceding read, so the busy window is crossed from both sides.

// File: rtl/dcd_pkg.sv
`timescale 1ns/1ps
package dcd_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_MRS  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_REF  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    WB_ONE  = 2'd0,
    WB_TWO  = 2'd1,
    WB_FOUR = 2'd2,
    WB_RSV  = 2'd3
  } wbank_e;

  // field positions inside mode register 2
  localparam int WMODE_LSB = 3;
  localparam int MBREF_BIT = 5;
  // at most this many banks per bitmap refresh
  localparam int MBREF_MAX = 4;

  function automatic cmd_e strobe_to_cmd(input logic cs_n, input logic we_n,
                                         input logic ref_n);
    cmd_e c;
    if (cs_n)                c = CMD_IDLE;
    else if (we_n && ref_n)  c = CMD_RD;
    else if (ref_n)          c = CMD_WR;
    else if (we_n)           c = CMD_REF;
    else                     c = CMD_MRS;
    return c;
  endfunction

  // true when bank index idx matches sel on the low 'keep' bits
  function automatic logic bank_hit(input int unsigned idx, input int unsigned sel,
                                    input int unsigned keep);
    int unsigned m;
    m = (32'd1 << keep) - 32'd1;
    return ((idx & m) == (sel & m));
  endfunction

endpackage

// File: rtl/dcd_decode.sv
`timescale 1ns/1ps
module dcd_decode
  import dcd_pkg::*;
(
  input  logic cs_n,
  input  logic we_n,
  input  logic ref_n,
  output cmd_e cmd
);
  always_comb cmd = strobe_to_cmd(cs_n, we_n, ref_n);
endmodule

// File: rtl/dcd_bank_map.sv
`timescale 1ns/1ps
module dcd_bank_map
  import dcd_pkg::*;
#(
  parameter int BA_W   = 4,
  parameter int ADDR_W = 20,
  localparam int NBANK = 1 << BA_W
) (
  input  logic [BA_W-1:0]   ba,
  input  logic [NBANK-1:0]  bitmap,
  input  wbank_e            wmode,
  input  logic              mb_ref,
  output logic [NBANK-1:0]  one_mask,
  output logic [NBANK-1:0]  wr_mask,
  output logic [NBANK-1:0]  ref_mask,
  output logic              ref_over
);
  localparam int KEEP_ONE  = BA_W;
  localparam int KEEP_TWO  = BA_W - 1;
  localparam int KEEP_FOUR = BA_W - 2;

  int unsigned keep;

  always_comb begin
    case (wmode)
      WB_TWO:  keep = KEEP_TWO;
      WB_FOUR: keep = KEEP_FOUR;
      default: keep = KEEP_ONE;
    endcase
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign one_mask[g] = bank_hit(g, 32'(ba), KEEP_ONE);
    assign wr_mask[g]  = bank_hit(g, 32'(ba), keep);
  end

  always_comb begin
    ref_over = 1'b0;
    ref_mask = one_mask;
    if (mb_ref) begin
      ref_over = ($countones(bitmap) > MBREF_MAX);
      ref_mask = ref_over ? '0 : bitmap;
    end
  end
endmodule

// File: rtl/dcd_busy_track.sv
`timescale 1ns/1ps
module dcd_busy_track #(
  parameter int NBANK    = 16,
  parameter int BUSY_CYC = 4,
  localparam int CW      = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] load,
  output logic [NBANK-1:0] busy,
  output logic             any_busy
);
  for (genvar g = 0; g < NBANK; g++) begin : g_cnt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (load[g])       cnt <= CW'(BUSY_CYC);
      else if (cnt != '0)     cnt <= cnt - 1'b1;
    end
    assign busy[g] = (cnt != '0);
  end
  assign any_busy = |busy;
endmodule

// File: rtl/dram_cmd_decode.sv
`timescale 1ns/1ps
module dram_cmd_decode
  import dcd_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int BA_W     = 4,
  parameter int BUSY_CYC = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    we_n,
  input  logic                    ref_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BA_W-1:0]         ba,
  output logic                    nop_p,
  output logic                    mrs_p,
  output logic                    rd_p,
  output logic                    wr_p,
  output logic                    ref_p,
  output logic [(1<<BA_W)-1:0]    bank_mask,
  output logic [ADDR_W-1:0]       loc_addr,
  output logic                    err,
  output logic [(1<<BA_W)-1:0]    bank_busy,
  output logic [ADDR_W-3:0]       mr0_q,
  output logic [ADDR_W-3:0]       mr1_q,
  output logic [ADDR_W-3:0]       mr2_q
);
  localparam int NBANK = 1 << BA_W;
  localparam int OP_W  = ADDR_W - 2;

  // named internal events, also watched by the checker
  cmd_e             cmd;
  logic             mrs_try;
  logic             any_busy;
  logic             mrs_ok;
  logic             ref_bad;
  logic [NBANK-1:0] one_mask, wr_mask, ref_mask;
  logic             ref_over;
  logic [NBANK-1:0] tgt_mask;
  wbank_e           wmode;
  logic             mb_ref;
  logic [1:0]       mr_sel;
  logic [OP_W-1:0]  mr_op;

  assign wmode  = wbank_e'(mr2_q[WMODE_LSB +: 2]);
  assign mb_ref = mr2_q[MBREF_BIT];
  assign mr_sel = addr[1:0];
  assign mr_op  = addr[ADDR_W-1:2];

  dcd_decode u_dec (
    .cs_n (cs_n),
    .we_n (we_n),
    .ref_n(ref_n),
    .cmd  (cmd)
  );

  dcd_bank_map #(.BA_W(BA_W), .ADDR_W(ADDR_W)) u_map (
    .ba      (ba),
    .bitmap  (addr[NBANK-1:0]),
    .wmode   (wmode),
    .mb_ref  (mb_ref),
    .one_mask(one_mask),
    .wr_mask (wr_mask),
    .ref_mask(ref_mask),
    .ref_over(ref_over)
  );

  dcd_busy_track #(.NBANK(NBANK), .BUSY_CYC(BUSY_CYC)) u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tgt_mask),
    .busy    (bank_busy),
    .any_busy(any_busy)
  );

  assign mrs_try = (cmd == CMD_MRS);
  assign mrs_ok  = mrs_try && !any_busy;
  assign ref_bad = (cmd == CMD_REF) && ref_over;

  always_comb begin
    case (cmd)
      CMD_RD:  tgt_mask = one_mask;
      CMD_WR:  tgt_mask = wr_mask;
      CMD_REF: tgt_mask = ref_mask;
      default: tgt_mask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nop_p     <= 1'b0;
      mrs_p     <= 1'b0;
      rd_p      <= 1'b0;
      wr_p      <= 1'b0;
      ref_p     <= 1'b0;
      err       <= 1'b0;
      bank_mask <= '0;
      loc_addr  <= '0;
    end else begin
      nop_p     <= (cmd == CMD_IDLE);
      mrs_p     <= mrs_ok;
      rd_p      <= (cmd == CMD_RD);
      wr_p      <= (cmd == CMD_WR);
      ref_p     <= (cmd == CMD_REF) && !ref_bad;
      err       <= (mrs_try && any_busy) || ref_bad;
      bank_mask <= tgt_mask;
      loc_addr  <= (cmd == CMD_RD || cmd == CMD_WR) ? addr : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mr0_q <= '0;
      mr1_q <= '0;
      mr2_q <= '0;
    end else if (mrs_ok) begin
      case (mr_sel)
        2'd0:    mr0_q <= mr_op;
        2'd1:    mr1_q <= mr_op;
        2'd2:    mr2_q <= mr_op;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dcd_chk.sv
`timescale 1ns/1ps
module dcd_chk #(
  parameter int NBANK = 16,
  parameter int OP_W  = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             nop_p,
  input logic             mrs_p,
  input logic             rd_p,
  input logic             wr_p,
  input logic             ref_p,
  input logic             err,
  input logic [NBANK-1:0] bank_mask,
  input logic [NBANK-1:0] bank_busy,
  input logic [OP_W-1:0]  mr0_q,
  input logic [OP_W-1:0]  mr1_q,
  input logic [OP_W-1:0]  mr2_q,
  input logic             mrs_try,
  input logic             any_busy
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nop_p |-> (bank_mask == '0 && !err));

  // R2
  single_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nop_p, mrs_p, rd_p, wr_p, ref_p, err}));

  // R3
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_p |-> ($countones(bank_mask) == 1));

  // R6
  wr_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_p |-> ($countones(bank_mask) == 1 || $countones(bank_mask) == 2 ||
              $countones(bank_mask) == 4));

  // R8
  ref_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_p |-> ($countones(bank_mask) <= 4));

  // R10
  mrs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrs_try && any_busy) |=> (err && !mrs_p && $stable(mr0_q) &&
                               $stable(mr1_q) && $stable(mr2_q)));

  // R9
  mr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mrs_p |-> ($stable(mr0_q) && $stable(mr1_q) && $stable(mr2_q)));

  // R11
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_p || wr_p || ref_p) |-> ((bank_busy & bank_mask) == bank_mask));
endmodule

bind dram_cmd_decode dcd_chk #(.NBANK(1 << BA_W), .OP_W(ADDR_W - 2)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .nop_p    (nop_p),
  .mrs_p    (mrs_p),
  .rd_p     (rd_p),
  .wr_p     (wr_p),
  .ref_p    (ref_p),
  .err      (err),
  .bank_mask(bank_mask),
  .bank_busy(bank_busy),
  .mr0_q    (mr0_q),
  .mr1_q    (mr1_q),
  .mr2_q    (mr2_q),
  .mrs_try  (mrs_try),
  .any_busy (any_busy)
);

// File: tb/dram_cmd_decode_tb_top.sv
`timescale 1ns/1ps
module dram_cmd_decode_tb_top;
  localparam int AW = 20;
  localparam int BW = 4;
  localparam int NB = 16;
  localparam int BC = 4;
  localparam int OW = AW - 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cs_n, we_n, ref_n;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  logic          nop_p, mrs_p, rd_p, wr_p, ref_p, err;
  logic [NB-1:0] bank_mask, bank_busy;
  logic [AW-1:0] loc_addr;
  logic [OW-1:0] mr0_q, mr1_q, mr2_q;

  dram_cmd_decode #(.ADDR_W(AW), .BA_W(BW), .BUSY_CYC(BC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .ref_n(ref_n),
    .addr(addr), .ba(ba), .nop_p(nop_p), .mrs_p(mrs_p), .rd_p(rd_p),
    .wr_p(wr_p), .ref_p(ref_p), .bank_mask(bank_mask), .loc_addr(loc_addr),
    .err(err), .bank_busy(bank_busy), .mr0_q(mr0_q), .mr1_q(mr1_q), .mr2_q(mr2_q)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int mbusy[NB];
  logic [OW-1:0] mr[3];

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one command at a falling edge, check the registered result one edge later
  task automatic issue(string tag, logic c, logic w, logic r,
                       logic [AW-1:0] a, logic [BW-1:0] b);
    logic [5:0]    ep;  // {nop, mrs, rd, wr, ref, err}
    logic [NB-1:0] em, eb;
    logic [AW-1:0] el;
    bit            anyb;
    int            wm, lo;
    anyb = 1'b0;
    for (int i = 0; i < NB; i++) if (mbusy[i] != 0) anyb = 1'b1;
    ep = '0; em = '0; el = '0;
    if (c) ep = 6'b100000;
    else if (w && r) begin
      ep = 6'b001000; em = NB'(1) << b; el = a;
    end else if (r) begin
      ep = 6'b000100; el = a; wm = int'(mr[2][4:3]);
      if (wm == 1) begin
        lo = int'(b) % 8; em = (NB'(1) << lo) | (NB'(1) << (lo + 8));
      end else if (wm == 2) begin
        lo = int'(b) % 4;
        for (int k = 0; k < 4; k++) em |= NB'(1) << (lo + 4 * k);
      end else em = NB'(1) << b;
    end else if (w) begin
      if (mr[2][5]) begin
        if ($countones(a[NB-1:0]) > 4) ep = 6'b000001;
        else begin ep = 6'b000010; em = a[NB-1:0]; end
      end else begin
        ep = 6'b000010; em = NB'(1) << b;
      end
    end else begin
      if (anyb) ep = 6'b000001;
      else begin
        ep = 6'b010000;
        if (a[1:0] != 2'd3) mr[a[1:0]] = a[AW-1:2];
      end
    end
    for (int i = 0; i < NB; i++) begin
      if (em[i]) mbusy[i] = BC;
      else if (mbusy[i] > 0) mbusy[i]--;
      eb[i] = (mbusy[i] != 0);
    end
    cs_n = c; we_n = w; ref_n = r; addr = a; ba = b;
    @(negedge clk);
    cmp(tag, "pulses", 64'({nop_p, mrs_p, rd_p, wr_p, ref_p, err}), 64'(ep));
    cmp(tag, "bank_mask", 64'(bank_mask), 64'(em));
    cmp(tag, "loc_addr", 64'(loc_addr), 64'(el));
    cmp(tag, "bank_busy", 64'(bank_busy), 64'(eb));
    cmp(tag, "mode_regs", {10'd0, mr0_q[17:0], mr1_q[17:0], mr2_q[17:0]},
        {10'd0, mr[0], mr[1], mr[2]});
  endtask

  task automatic idle(string tag);
    for (int i = 0; i <= BC; i++) issue(tag, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  // mode register load; op bits [4:3] write width, bit [5] refresh method
  task automatic load_mr(string tag, logic [1:0] sel, logic [OW-1:0] op);
    issue(tag, 1'b0, 1'b0, 1'b0, {op, sel}, '0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NB; i++) mbusy[i] = 0;
    for (int i = 0; i < 3; i++) mr[i] = '0;
    rst_n = 1'b0; cs_n = 1'b0; we_n = 1'b0; ref_n = 1'b0; addr = '1; ba = '1;
    repeat (3) @(negedge clk);
    // R12 reset state
    cmp("R12", "outputs", 64'({nop_p, mrs_p, rd_p, wr_p, ref_p, err, bank_mask,
                               bank_busy, loc_addr}), 64'd0);
    cmp("R12", "mode_regs", 64'({mr0_q, mr1_q, mr2_q}), 64'd0);
    rst_n = 1'b1;

    // R1 idle with every strobe pattern and busy addresses
    for (int p = 0; p < 4; p++)
      issue("R1", 1'b1, p[1], p[0], AW'(32'hA5A5A + p), BW'(p * 5));

    // R2 R3 reads on every bank
    for (int b = 0; b < NB; b++)
      issue("R3", 1'b0, 1'b1, 1'b1, AW'(32'h13579 * (b + 1)), BW'(b));
    idle("R11");

    // R4 R5 R6 writes in every width setting
    for (int m = 0; m < 4; m++) begin
      load_mr("R9", 2'd2, OW'(m << 3));
      for (int b = 0; b < NB; b++)
        issue(m == 1 ? "R5" : (m == 2 ? "R6" : "R4"),
              1'b0, 1'b0, 1'b1, AW'(32'h2468A + b), BW'(b));
      idle("R11");
    end

    // R7 bank-addressed refresh, addr ignored
    load_mr("R9", 2'd2, '0);
    for (int b = 0; b < NB; b++)
      issue("R7", 1'b0, 1'b1, 1'b0, AW'(32'hFFFFF - b), BW'(b));
    idle("R11");

    // R8 bitmap refresh over every bitmap, ba ignored
    load_mr("R9", 2'd2, OW'(1 << 5));
    for (int v = 0; v < 65536; v++)
      issue("R8", 1'b0, 1'b1, 1'b0, AW'(v) | AW'(32'hF0000), BW'(v));
    idle("R11");

    // R9 register selection, selector 3 ignored
    load_mr("R9", 2'd0, OW'(32'h2ABCD));
    load_mr("R9", 2'd1, OW'(32'h15432));
    load_mr("R9", 2'd3, OW'(32'h3FFFF));
    load_mr("R9", 2'd2, OW'(32'h00008));

    // R10 R11 load at every distance from a read
    for (int k = 0; k <= BC + 1; k++) begin
      idle("R11");
      issue("R11", 1'b0, 1'b1, 1'b1, AW'(k), BW'(k + 3));
      for (int j = 0; j < k; j++) issue("R11", 1'b1, 1'b1, 1'b1, '0, '0);
      load_mr("R10", 2'(k % 3), OW'(32'h100 + k));
    end
    // R10 blocked after a write as well
    idle("R11");
    issue("R10", 1'b0, 1'b0, 1'b1, AW'(7), BW'(9));
    load_mr("R10", 2'd0, OW'(32'h3FFFF));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule